// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a small on-chip register file. An SPI master selects it with an active-low chip select. The master sends an opcode byte, and the block then runs one of four commands. The first reports whether the sensor data is valid. The second reports the result of the most recent register transaction. The third is a burst read and the fourth is a burst write. Both bursts begin at an address given in the second byte and step upward by one after each data byte. During a burst the block returns the opcode and the address on MISO, one byte later than it received them. During a burst write it also returns each data byte one byte later.

The serial pins are sampled in the system clock domain. A parallel strobe port drives the register file. Read data and its valid flag must be returned in the same clock cycle as the read strobe. A status byte records the result of every register access. Its error flag is sticky: only a completed status query clears it.

Top module: `spireg_slave`

## Requirements
- R1: The SPI link uses mode 0 with the most significant bit first. MOSI is taken on rising SCLK edges. MISO changes only after falling SCLK edges. MISO reads 0 while chip select is high and during the first byte of a transfer.
- R2: During the second byte time of every transfer, MISO returns the opcode received in the first byte. This holds for unknown opcodes as well.
- R3: Opcode 0xA6 is the sensor query. Its third byte carries the `sens_ok` input in bit 7 and zeros in bits 6..0. If `sens_ok` is 0 when this byte is loaded, the error flag is set.
- R4: Opcode 0x9C is the status query. Its third byte is the status byte: bit 7 error, bits 6..4 zero, bit 3 address refused, bit 2 access failed, bit 1 busy, bit 0 data valid. Its fourth byte is 0x00. Busy is 1 only while a burst is selected, so a status query reads it as 0.
- R5: Opcode 0x8A is the burst read. Byte 2 is the start address. Byte 3 returns the address. Byte 4 and each later byte return the contents of consecutive addresses, each fetched with one `rf_rd` strobe.
- R6: Opcode 0xCF is the burst write. Byte 2 is the start address and bytes 3 onward are data. Each data byte is written with one `rf_wr` strobe to consecutive addresses. MISO returns the address and then each data byte, one byte time late.
- R7: An access to an address of 0x40 or above strobes nothing. It sets the refused and failed bits, clears the valid bit, returns 0x00 for read data and leaves the address counter where it is.
- R8: A read that returns `rf_rvalid` = 0 sets the failed bit, clears the refused and valid bits, returns 0x00 and does not advance the address counter.
- R9: A successful access sets the valid bit, clears the failed and refused bits, and advances the address counter by one.
- R10: Any other opcode sets the error flag, and the rest of that transfer reads 0x00. Later accesses do not clear the flag. It clears only when a status query has shifted out its status byte.
- R11: Raising chip select in the middle of a byte aborts the command, so the partial byte causes no write. The next transfer begins again with opcode decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| sens_ok | input | 1 | Sensor data valid flag |
| rf_addr | output | ADDR_W | Register file address |
| rf_rd | output | 1 | Register read strobe, one clock |
| rf_rdata | input | 8 | Read data, valid in the same clock as `rf_rd` |
| rf_rvalid | input | 1 | Read data usable, sampled with `rf_rd` |
| rf_wr | output | 1 | Register write strobe, one clock |
| rf_wdata | output | 8 | Write data |

## Verification
Each SCLK edge takes two synchronizer clocks and one edge-detect clock to reach the logic. A byte decision therefore lands about three clocks after the eighth rising edge. The register strobe follows one clock later, and the reply bit appears on MISO about three clocks after the next falling edge. The bench holds each SCLK phase for eight clocks. It compares MISO only on the rising edge that follows, so every reply byte is checked exactly in the byte time the requirements assign to it. Register strobes are checked on the falling clock edge of the cycle in which they occur, against the writes queued for that transfer.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_SENSE = 8'hA6;
  localparam logic [BYTE_W-1:0] OP_STAT  = 8'h9C;
  localparam logic [BYTE_W-1:0] OP_BRD   = 8'h8A;
  localparam logic [BYTE_W-1:0] OP_BWR   = 8'hCF;

  typedef enum logic [3:0] {
    PH_OPC, PH_SV, PH_ST1, PH_ST2, PH_RADR, PH_RDAT, PH_WADR, PH_WDAT, PH_END
  } phase_t;

  typedef struct packed {
    logic err;
    logic dismiss;
    logic fail;
    logic busy;
    logic valid;
  } stat_t;

  function automatic logic [BYTE_W-1:0] stat_byte(input stat_t s);
    return {s.err, 3'b000, s.dismiss, s.fail, s.busy, s.valid};
  endfunction

  function automatic logic [BYTE_W-1:0] sense_byte(input logic ok);
    return {ok, {(BYTE_W-1){1'b0}}};
  endfunction

  function automatic logic addr_in_range(input logic [BYTE_W-1:0] a, input int aw);
    return (a >> aw) == '0;
  endfunction

  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    return (op == OP_SENSE) || (op == OP_STAT) || (op == OP_BRD) || (op == OP_BWR);
  endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);

  logic [STAGES-1:0] cs_p, sck_p, mo_p;
  logic              sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      mo_p  <= '0;
      sck_d <= 1'b0;
    end else begin
      cs_p[0]  <= cs_n;
      sck_p[0] <= sclk;
      mo_p[0]  <= mosi;
      for (int i = 1; i < STAGES; i++) begin
        cs_p[i]  <= cs_p[i-1];
        sck_p[i] <= sck_p[i-1];
        mo_p[i]  <= mo_p[i-1];
      end
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign cs_act    = ~cs_p[STAGES-1];
  assign sclk_rise =  sck_p[STAGES-1] & ~sck_d;
  assign sclk_fall = ~sck_p[STAGES-1] &  sck_d;
  assign mosi_s    =  mo_p[STAGES-1];

endmodule

// File: rtl/spireg_shift.sv
module spireg_shift
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);

  logic [BYTE_W-2:0] rx_sh;
  logic [BIT_CW-1:0] bitcnt;
  logic              miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh  <= '0;
      bitcnt <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act) begin
      bitcnt <= '0;
      miso_q <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sh  <= {rx_sh[BYTE_W-3:0], mosi_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (sclk_fall) miso_q <= tx_byte[~bitcnt];
    end
  end

  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = cs_act & sclk_rise & (bitcnt == BIT_CW'(BYTE_W-1));
  assign miso      = miso_q;

endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
  import spireg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              sens_ok,
  input  logic [BYTE_W-1:0] rf_rdata,
  input  logic              rf_rvalid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic              acc_ok,
  output logic              acc_fail,
  output logic [BYTE_W-1:0] acc_addr,
  output logic              err_flag,
  output logic              err_clr
);

  phase_t            ph;
  stat_t             st;
  logic [BYTE_W-1:0] addr_q, tx_q, wdat_q;
  logic              rd_pend, wr_pend;
  logic              addr_ok, acc_go, err_set;

  assign addr_ok  = addr_in_range(addr_q, ADDR_W);
  assign acc_go   = rd_pend | wr_pend;
  assign acc_ok   = acc_go & addr_ok & (wr_pend | rf_rvalid);
  assign acc_fail = acc_go & ~acc_ok;
  assign err_set  = byte_done & (((ph == PH_OPC) & ~op_known(rx_byte)) |
                                 ((ph == PH_SV) & ~sens_ok));
  assign err_clr  = byte_done & (ph == PH_ST2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_OPC;
      st      <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      wdat_q  <= '0;
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      st.err  <= err_set | (st.err & ~err_clr);
      if (!cs_act) begin
        ph      <= PH_OPC;
        tx_q    <= '0;
        st.busy <= 1'b0;
      end else begin
        if (byte_done) begin
          case (ph)
            PH_OPC: begin
              tx_q <= rx_byte;
              case (rx_byte)
                OP_SENSE: ph <= PH_SV;
                OP_STAT:  ph <= PH_ST1;
                OP_BRD:   begin ph <= PH_RADR; st.busy <= 1'b1; end
                OP_BWR:   begin ph <= PH_WADR; st.busy <= 1'b1; end
                default:  ph <= PH_END;
              endcase
            end
            PH_SV:   begin tx_q <= sense_byte(sens_ok); ph <= PH_END; end
            PH_ST1:  begin tx_q <= stat_byte(st);       ph <= PH_ST2; end
            PH_ST2:  begin tx_q <= '0;                  ph <= PH_END; end
            PH_RADR: begin addr_q <= rx_byte; tx_q <= rx_byte; ph <= PH_RDAT; end
            PH_RDAT: rd_pend <= 1'b1;
            PH_WADR: begin addr_q <= rx_byte; tx_q <= rx_byte; ph <= PH_WDAT; end
            PH_WDAT: begin wdat_q <= rx_byte; tx_q <= rx_byte; wr_pend <= 1'b1; end
            default: tx_q <= '0;
          endcase
        end
        if (acc_go) begin
          if (rd_pend) tx_q <= acc_ok ? rf_rdata : '0;
          st.valid   <= acc_ok;
          st.fail    <= ~acc_ok;
          st.dismiss <= ~addr_ok;
          if (acc_ok) addr_q <= addr_q + 8'd1;
        end
      end
    end
  end

  assign tx_byte  = tx_q;
  assign rf_addr  = addr_q[ADDR_W-1:0];
  assign rf_rd    = rd_pend & addr_ok;
  assign rf_wr    = wr_pend & addr_ok;
  assign rf_wdata = wdat_q;
  assign acc_addr = addr_q;
  assign err_flag = st.err;

endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              sens_ok,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_rd,
  input  logic [7:0]        rf_rdata,
  input  logic              rf_rvalid,
  output logic              rf_wr,
  output logic [7:0]        rf_wdata
);

  logic              cs_act, sclk_rise, sclk_fall, mosi_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte, acc_addr;
  logic              acc_ok, acc_fail, err_flag, err_clr;

  spireg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
  );

  spireg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .tx_byte(tx_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spireg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .sens_ok(sens_ok), .rf_rdata(rf_rdata), .rf_rvalid(rf_rvalid),
    .tx_byte(tx_byte), .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_wdata(rf_wdata), .acc_ok(acc_ok), .acc_fail(acc_fail), .acc_addr(acc_addr),
    .err_flag(err_flag), .err_clr(err_clr)
  );

endmodule

// File: rtl/spireg_chk.sv
module spireg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       sclk_fall,
  input logic       miso,
  input logic       rf_rd,
  input logic       rf_wr,
  input logic       acc_ok,
  input logic       acc_fail,
  input logic [7:0] acc_addr,
  input logic       err_flag,
  input logic       err_clr
);

  // R1: MISO moves only after a falling SCLK edge
  a_r1_miso_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sclk_fall) |=> $stable(miso));

  // R1: MISO low while deselected
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);

  // R5, R6: read and write strobes never coincide
  a_r5_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_rd && rf_wr));

  // R6: one write strobe per data byte
  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr);

  // R9: successful access advances the counter by one
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> acc_addr == $past(acc_addr) + 8'd1);

  // R7, R8: failed access freezes the counter
  a_r7_addr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fail |=> $stable(acc_addr));

  // R10: error flag is sticky until a status byte leaves
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

endmodule

bind spireg_slave spireg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .miso(spi_miso), .rf_rd(rf_rd), .rf_wr(rf_wr), .acc_ok(acc_ok),
  .acc_fail(acc_fail), .acc_addr(acc_addr), .err_flag(err_flag), .err_clr(err_clr)
);

// File: tb/sim_spireg_slave.sv
module sim_spireg_slave;

  localparam logic [7:0] C_SV = 8'hA6, C_ST = 8'h9C, C_RD = 8'h8A, C_WR = 8'hCF;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, sens_ok = 1'b1;
  logic       miso, rf_rd, rf_wr, rf_rvalid;
  logic [5:0] rf_addr;
  logic [7:0] rf_rdata, rf_wdata;
  logic [7:0] mem [64];
  logic       nok_en = 1'b0;
  logic [5:0] nok_a = '0;
  int         total = 0, bad = 0;
  bit         finished = 0;

  logic [7:0] mq[$];
  logic [7:0] ev[$];
  string      et[$];
  logic [13:0] wq[$];
  string      wt[$];

  always #5 clk = ~clk;

  assign rf_rdata  = mem[rf_addr];
  assign rf_rvalid = !(nok_en && rf_addr == nok_a);

  spireg_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .sens_ok(sens_ok), .rf_addr(rf_addr), .rf_rd(rf_rd),
    .rf_rdata(rf_rdata), .rf_rvalid(rf_rvalid), .rf_wr(rf_wr), .rf_wdata(rf_wdata)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: queue MOSI byte and the MISO byte expected in the same slot
  task automatic b(input logic [7:0] tx, input logic [7:0] ex, input string tag);
    mq.push_back(tx);
    ev.push_back(ex);
    et.push_back(tag);
  endtask

  task automatic we(input logic [5:0] a, input logic [7:0] d, input string tag);
    wq.push_back({a, d});
    wt.push_back(tag);
  endtask

  task automatic send_bits(input logic [7:0] t, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = t[i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic go();
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    while (mq.size() > 0) send_bits(mq.pop_front(), 8);
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic status(input logic [7:0] s, input string tag);
    b(C_ST, 8'h00, tag);
    b(8'h00, C_ST, tag);
    b(8'h00, s, tag);
    b(8'h00, 8'h00, tag);
    go();
  endtask

  // monitor: assembles MISO bytes at rising SCLK and pops expectations
  initial begin
    logic [7:0] sh;
    int n;
    sh = '0;
    n = 0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) n = 0;
      else begin
        sh = {sh[6:0], miso};
        n++;
        if (n == 8) begin
          n = 0;
          if (ev.size() == 0) chk(0, "R1 unexpected MISO byte", sh, 0);
          else chk(sh == ev[0], et[0], sh, ev[0]);
          if (ev.size() > 0) begin
            void'(ev.pop_front());
            void'(et.pop_front());
          end
        end
      end
    end
  end

  // monitor: register file writes
  initial begin
    forever begin
      @(negedge clk);
      if (rf_wr) begin
        if (wq.size() == 0) chk(0, "R7 R11 unexpected write", {rf_addr, rf_wdata}, 0);
        else begin
          chk({rf_addr, rf_wdata} == wq[0], wt[0], {rf_addr, rf_wdata}, wq[0]);
          void'(wq.pop_front());
          void'(wt.pop_front());
        end
        mem[rf_addr] = rf_wdata;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = seed(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(miso == 1'b0, "R1 reset miso", miso, 0);
    chk(rf_rd == 1'b0 && rf_wr == 1'b0, "R1 reset strobes", {rf_rd, rf_wr}, 0);

    status(8'h00, "R4 status after reset");

    b(C_SV, 8'h00, "R3 sense"); b(8'h00, C_SV, "R2 sense echo"); b(8'h00, 8'h80, "R3 sense ok");
    go();

    b(C_WR, 8'h00, "R6"); b(8'h10, C_WR, "R2 write echo"); b(8'h11, 8'h10, "R6 addr echo");
    b(8'h22, 8'h11, "R6 data echo"); b(8'h33, 8'h22, "R6 data echo");
    we(6'h10, 8'h11, "R6 w0"); we(6'h11, 8'h22, "R6 w1"); we(6'h12, 8'h33, "R6 w2");
    go();
    status(8'h01, "R9 status after write");

    b(C_RD, 8'h00, "R5"); b(8'h10, C_RD, "R2 read echo"); b(8'h00, 8'h10, "R5 addr echo");
    b(8'h00, 8'h11, "R5 d0"); b(8'h00, 8'h22, "R5 d1"); b(8'h00, 8'h33, "R5 d2");
    go();

    b(C_RD, 8'h00, "R7"); b(8'h3E, C_RD, "R7 echo"); b(8'h00, 8'h3E, "R7 addr echo");
    b(8'h00, seed(62), "R5 d3e"); b(8'h00, seed(63), "R5 d3f");
    b(8'h00, 8'h00, "R7 beyond"); b(8'h00, 8'h00, "R7 frozen");
    go();
    status(8'h0C, "R7 status refused");

    b(C_RD, 8'h00, "R9"); b(8'h10, C_RD, "R9 echo"); b(8'h00, 8'h10, "R9 addr"); b(8'h00, 8'h11, "R9 data");
    go();
    b(C_WR, 8'h00, "R7 wr"); b(8'h50, C_WR, "R7 wr echo"); b(8'hAA, 8'h50, "R7 wr addr echo");
    b(8'hBB, 8'hAA, "R7 wr data echo");
    go();
    status(8'h0C, "R7 status after bad write");

    nok_en = 1'b1; nok_a = 6'h06;
    b(C_RD, 8'h00, "R8"); b(8'h05, C_RD, "R8 echo"); b(8'h00, 8'h05, "R8 addr echo");
    b(8'h00, seed(5), "R8 d5"); b(8'h00, 8'h00, "R8 not ready"); b(8'h00, 8'h00, "R8 frozen");
    go();
    status(8'h04, "R8 status fail");
    nok_en = 1'b0;
    b(C_RD, 8'h00, "R9"); b(8'h06, C_RD, "R9 echo"); b(8'h00, 8'h06, "R9 addr"); b(8'h00, seed(6), "R9 retry");
    go();
    status(8'h01, "R9 status recovered");

    b(8'h55, 8'h00, "R10"); b(8'h12, 8'h55, "R2 bad op echo"); b(8'h34, 8'h00, "R10 drain");
    go();
    b(C_RD, 8'h00, "R10"); b(8'h10, C_RD, "R10 echo"); b(8'h00, 8'h10, "R10 addr"); b(8'h00, 8'h11, "R10 data");
    go();
    status(8'h81, "R10 error kept");
    status(8'h01, "R10 error cleared");

    sens_ok = 1'b0;
    b(C_SV, 8'h00, "R3"); b(8'h00, C_SV, "R3 echo"); b(8'h00, 8'h00, "R3 sense bad");
    go();
    sens_ok = 1'b1;
    status(8'h81, "R3 error set");
    status(8'h01, "R3 error cleared");

    // R11: abort inside the first data byte of a write
    b(C_WR, 8'h00, "R11"); b(8'h20, C_WR, "R11 echo");
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    while (mq.size() > 0) send_bits(mq.pop_front(), 8);
    send_bits(8'h77, 4);
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
    status(8'h01, "R11 status after abort");
    b(C_RD, 8'h00, "R11"); b(8'h20, C_RD, "R11 echo"); b(8'h00, 8'h20, "R11 addr");
    b(8'h00, seed(32), "R11 untouched");
    go();

    chk(miso == 1'b0, "R1 idle miso", miso, 0);
    chk(ev.size() == 0, "R1 pending MISO bytes", ev.size(), 0);
    chk(wq.size() == 0, "R6 pending writes", wq.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule